// File: doc/BRIEF.md
# Phase-Accumulator Tone Oscillator

This block is the tone source of one sound-generator voice. A wide phase accumulator advances by a programmable step every clock, and its upper bits are shaped into a 12-bit digital sample: a sawtooth, a triangle folded from the ramp, a variable-width pulse, or the bitwise AND of any of these. A byte-wide write port loads the step size, the pulse threshold and a control byte. Two control bits couple the voice to a neighbouring voice. Ring modulation uses the neighbour's accumulator MSB to change the triangle fold. Hard sync restarts the ramp on the neighbour's MSB rising edge.

The sample is produced on every clock with no back-pressure. The output is a free-running level, not a stream, so it has no valid/ready pair and the consumer simply samples it. The write port is plain as well: a write is accepted in the cycle `wr_en` is high. The voice exports its own MSB and a one-cycle MSB-rising flag, so that voices can be chained in a ring.

Top module: `tone_osc`

## Requirements
- R1: When the test bit is low and no sync applies, each clock adds the 16-bit step to the 24-bit accumulator, modulo 2^24; `msb_o` is accumulator bit 23.
- R2: A clock edge that sees the test bit high loads zero into the accumulator; counting restarts from zero once the bit is cleared.
- R3: Reset sets the accumulator to 0x555555 (all even bits set) and clears the step, the threshold, the control byte, the held sample and the flags.
- R4: With the sawtooth selected, the sample equals accumulator bits 23..12.
- R5: With the triangle selected, accumulator bits 22..12 are inverted when the fold bit is 1 and passed through when it is 0, then shifted left one place with a 0 appended.
- R6: With ring modulation on, the fold bit is bit 23 XOR NOT `ring_msb_i`; with it off, the fold bit is bit 23.
- R7: The pulse shape is 0xFFF when accumulator bits 23..12 were greater than or equal to the threshold on the previous cycle, and 0x000 otherwise.
- R8: While the test bit is high, the pulse shape is 0xFFF whatever the threshold.
- R9: `msb_rise_o` is high for one cycle after an edge in which the addition carried bit 23 from 0 to 1. It is low while test is high.
- R10: When sync is enabled and `sync_rise_i` is high at an edge, the accumulator becomes zero at that edge.
- R11: Writes use the following addresses: 0 sets step bits 7..0, 1 sets step bits 15..8, 2 sets threshold bits 7..0, 3 sets threshold bits 11..8 from data bits 3..0, and 4 sets the control byte. Addresses 5 to 7 have no effect. The control byte holds sync in bit 0, ring in bit 1, test in bit 2, triangle in bit 4, sawtooth in bit 5 and pulse in bit 6. Bits 3 and 7 are ignored.
- R12: With several shapes selected, the sample is their bitwise AND. With none selected, the sample keeps the value it had in the last cycle in which a shape was selected.
- R13: `osc_rd_o` equals sample bits 11..4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| ring_msb_i | input | 1 | Accumulator MSB of the modulating voice |
| sync_rise_i | input | 1 | MSB-rising flag of the sync source voice |
| wave_o | output | 12 | Waveform sample |
| osc_rd_o | output | 8 | Upper 8 bits of the sample |
| msb_o | output | 1 | Accumulator MSB |
| msb_rise_o | output | 1 | One-cycle MSB-rising flag |

## Verification
The bench builds the block with its default parameters: a 24-bit accumulator, a 16-bit step and 12-bit samples and threshold. With a step of 0xFFFF, one ramp period lasts 256 clocks. This lets the bench sweep every shape, every fold position and a threshold grid covering 0x000 to 0xFFF, as well as the wrap, rise and sync cases, within a few thousand cycles. It compares all outputs against an arithmetic model on every cycle.

// File: rtl/osc_pkg.sv
package osc_pkg;

  typedef enum logic [2:0] {
    A_STEP_LO  = 3'd0,
    A_STEP_HI  = 3'd1,
    A_THR_LO   = 3'd2,
    A_THR_HI   = 3'd3,
    A_CTRL     = 3'd4
  } osc_addr_e;

  // Control bits kept from the control byte (bits 3 and 7 are dropped)
  typedef struct packed {
    logic pulse_sel;  // byte bit 6
    logic saw_sel;    // byte bit 5
    logic tri_sel;    // byte bit 4
    logic test;       // byte bit 2
    logic ring;       // byte bit 1
    logic sync;       // byte bit 0
  } osc_ctrl_t;

endpackage

// File: rtl/osc_regs.sv
module osc_regs
  import osc_pkg::*;
#(
  parameter int FREQ_W = 16,
  parameter int PW_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic [FREQ_W-1:0] step_o,
  output logic [PW_W-1:0]   thr_o,
  output osc_ctrl_t         ctrl_o
);
  localparam int STEP_HI_W = FREQ_W - 8;
  localparam int THR_HI_W  = PW_W - 8;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_o <= '0;
      thr_o  <= '0;
      ctrl_o <= '0;
    end else if (wr_en) begin
      case (osc_addr_e'(wr_addr))
        A_STEP_LO: step_o[7:0]        <= wr_data;
        A_STEP_HI: step_o[FREQ_W-1:8] <= wr_data[STEP_HI_W-1:0];
        A_THR_LO:  thr_o[7:0]         <= wr_data;
        A_THR_HI:  thr_o[PW_W-1:8]    <= wr_data[THR_HI_W-1:0];
        A_CTRL: begin
          ctrl_o.sync      <= wr_data[0];
          ctrl_o.ring      <= wr_data[1];
          ctrl_o.test      <= wr_data[2];
          ctrl_o.tri_sel   <= wr_data[4];
          ctrl_o.saw_sel   <= wr_data[5];
          ctrl_o.pulse_sel <= wr_data[6];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/osc_phase.sv
module osc_phase #(
  parameter int              ACC_W  = 24,
  parameter int              FREQ_W = 16,
  parameter logic [ACC_W-1:0] INIT  = 24'h555555
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test,
  input  logic              sync_en,
  input  logic              sync_rise_i,
  input  logic [FREQ_W-1:0] step,
  output logic [ACC_W-1:0]  acc_o,
  output logic              rise_o
);
  localparam int PAD = ACC_W - FREQ_W;

  logic [ACC_W-1:0] sum;
  assign sum = acc_o + {{PAD{1'b0}}, step};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_o  <= INIT;
      rise_o <= 1'b0;
    end else if (test) begin
      acc_o  <= '0;
      rise_o <= 1'b0;
    end else begin
      rise_o <= ~acc_o[ACC_W-1] & sum[ACC_W-1];
      acc_o  <= (sync_en && sync_rise_i) ? '0 : sum;
    end
  end
endmodule

// File: rtl/osc_shaper.sv
module osc_shaper #(
  parameter int OUT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OUT_W-1:0] phase_top,
  input  logic [OUT_W-1:0] thr,
  input  logic             tri_sel,
  input  logic             saw_sel,
  input  logic             pulse_sel,
  input  logic             ring_en,
  input  logic             test,
  input  logic             ring_msb_i,
  output logic [OUT_W-1:0] wave_o
);
  localparam int NSHAPE = 3;

  logic              pulse_lvl;
  logic              fold;
  logic [OUT_W-2:0]  low;
  logic [OUT_W-1:0]  shapes [NSHAPE];
  logic [NSHAPE-1:0] sel;
  logic [OUT_W-1:0]  mixed;
  logic [OUT_W-1:0]  hold_q;

  assign fold = phase_top[OUT_W-1] ^ (ring_en & ~ring_msb_i);
  assign low  = phase_top[OUT_W-2:0];

  assign shapes[0] = {fold ? ~low : low, 1'b0};
  assign shapes[1] = phase_top;
  assign shapes[2] = {OUT_W{pulse_lvl | test}};
  assign sel       = {pulse_sel, saw_sel, tri_sel};

  always_comb begin
    mixed = '1;
    for (int i = 0; i < NSHAPE; i++) begin
      if (sel[i]) mixed = mixed & shapes[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_lvl <= 1'b0;
      hold_q    <= '0;
    end else begin
      pulse_lvl <= (phase_top >= thr);
      if (|sel) hold_q <= mixed;
    end
  end

  assign wave_o = (|sel) ? mixed : hold_q;
endmodule

// File: rtl/tone_osc.sv
module tone_osc
  import osc_pkg::*;
#(
  parameter int ACC_W  = 24,
  parameter int FREQ_W = 16,
  parameter int OUT_W  = 12,
  parameter int RD_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             ring_msb_i,
  input  logic             sync_rise_i,
  output logic [OUT_W-1:0] wave_o,
  output logic [RD_W-1:0]  osc_rd_o,
  output logic             msb_o,
  output logic             msb_rise_o
);
  logic [FREQ_W-1:0] step_q;
  logic [OUT_W-1:0]  thr_q;
  osc_ctrl_t         ctrl_q;
  logic [ACC_W-1:0]  acc_q;

  osc_regs #(.FREQ_W(FREQ_W), .PW_W(OUT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .step_o(step_q), .thr_o(thr_q), .ctrl_o(ctrl_q)
  );

  osc_phase #(.ACC_W(ACC_W), .FREQ_W(FREQ_W),
              .INIT({(ACC_W/2){2'b01}})) phase_i (
    .clk(clk), .rst_n(rst_n), .test(ctrl_q.test), .sync_en(ctrl_q.sync),
    .sync_rise_i(sync_rise_i), .step(step_q), .acc_o(acc_q), .rise_o(msb_rise_o)
  );

  osc_shaper #(.OUT_W(OUT_W)) shaper_i (
    .clk(clk), .rst_n(rst_n), .phase_top(acc_q[ACC_W-1 -: OUT_W]),
    .thr(thr_q), .tri_sel(ctrl_q.tri_sel), .saw_sel(ctrl_q.saw_sel),
    .pulse_sel(ctrl_q.pulse_sel), .ring_en(ctrl_q.ring), .test(ctrl_q.test),
    .ring_msb_i(ring_msb_i), .wave_o(wave_o)
  );

  assign msb_o    = acc_q[ACC_W-1];
  assign osc_rd_o = wave_o[OUT_W-1 -: RD_W];
endmodule

// File: rtl/tone_osc_chk.sv
module tone_osc_chk #(
  parameter int ACC_W  = 24,
  parameter int FREQ_W = 16,
  parameter int OUT_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ACC_W-1:0]  acc,
  input logic [FREQ_W-1:0] step,
  input logic              test,
  input logic              sync_en,
  input logic [2:0]        sel,
  input logic              sync_rise_i,
  input logic [OUT_W-1:0]  wave_o,
  input logic              msb_o,
  input logic              msb_rise_o
);
  localparam int PAD = ACC_W - FREQ_W;

  // R1
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(test) && !($past(sync_en) && $past(sync_rise_i)))
    |-> acc == ACC_W'($past(acc) + {{PAD{1'b0}}, $past(step)}));

  // R2
  test_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(test)) |-> acc == '0);

  // R8
  test_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test && sel == 3'b100) |-> wave_o == '1);

  // R9
  rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && msb_rise_o) |-> !$past(msb_o));

  // R10
  sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sync_en) && $past(sync_rise_i)) |-> acc == '0);

  // R12
  hold_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && sel == 3'b000 && $past(sel) == 3'b000) |-> $stable(wave_o));
endmodule

bind tone_osc tone_osc_chk #(.ACC_W(ACC_W), .FREQ_W(FREQ_W), .OUT_W(OUT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .acc(acc_q), .step(step_q), .test(ctrl_q.test),
  .sync_en(ctrl_q.sync), .sel({ctrl_q.pulse_sel, ctrl_q.saw_sel, ctrl_q.tri_sel}),
  .sync_rise_i(sync_rise_i), .wave_o(wave_o), .msb_o(msb_o), .msb_rise_o(msb_rise_o)
);

// File: tb/tone_osc_tb_top.sv
module tone_osc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        ring_msb_i = 1'b0;
  logic        sync_rise_i = 1'b0;
  logic [11:0] wave_o;
  logic [7:0]  osc_rd_o;
  logic        msb_o;
  logic        msb_rise_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;
  bit ring_pat = 1'b0;
  bit sync_pat = 1'b0;

  // arithmetic model state
  logic [23:0] m_acc = 24'h555555;
  logic [15:0] m_step = '0;
  logic [11:0] m_thr = '0;
  logic [7:0]  m_ctrl = '0;
  logic        m_pl = 1'b0;
  logic        m_rise = 1'b0;
  logic [11:0] m_hold = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tone_osc dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ring_msb_i(ring_msb_i), .sync_rise_i(sync_rise_i), .wave_o(wave_o),
    .osc_rd_o(osc_rd_o), .msb_o(msb_o), .msb_rise_o(msb_rise_o)
  );

  function automatic logic [11:0] shape(input logic [23:0] a, input logic pl,
                                        input logic [7:0] c, input logic rm);
    logic [11:0] t;
    logic        f;
    logic [11:0] tri_v;
    logic [11:0] r;
    t = a[23:12];
    f = t[11] ^ (c[1] & ~rm);
    tri_v = {f ? ~t[10:0] : t[10:0], 1'b0};
    r = 12'hFFF;
    if (c[4]) r = r & tri_v;
    if (c[5]) r = r & t;
    if (c[6]) r = r & ((pl | c[2]) ? 12'hFFF : 12'h000);
    return r;
  endfunction

  function automatic logic [11:0] expect_wave();
    if (|m_ctrl[6:4]) return shape(m_acc, m_pl, m_ctrl, ring_msb_i);
    return m_hold;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // one clock: model update at the edge, compare at the falling edge
  task automatic step(input string tag);
    logic [23:0] sum;
    @(posedge clk);
    cyc++;
    if (rst_n) begin
      sum = m_acc + {8'h00, m_step};
      if (|m_ctrl[6:4]) m_hold = shape(m_acc, m_pl, m_ctrl, ring_msb_i);
      m_pl = (m_acc[23:12] >= m_thr);
      if (m_ctrl[2]) begin
        m_acc = '0;
        m_rise = 1'b0;
      end else begin
        m_rise = ~m_acc[23] & sum[23];
        m_acc = (m_ctrl[0] && sync_rise_i) ? 24'h0 : sum;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_step[7:0] = wr_data;
          3'd1: m_step[15:8] = wr_data;
          3'd2: m_thr[7:0] = wr_data;
          3'd3: m_thr[11:8] = wr_data[3:0];
          3'd4: m_ctrl = wr_data & 8'h77;
          default: ;
        endcase
      end
    end
    @(negedge clk);
    chk(tag, int'(wave_o), int'(expect_wave()));
    chk("R13", int'(osc_rd_o), int'(expect_wave() >> 4));
    chk("R1", int'(msb_o), int'(m_acc[23]));
    chk("R9", int'(msb_rise_o), int'(m_rise));
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(tag);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      ring_msb_i  = ring_pat ? cyc[3] : 1'b0;
      sync_rise_i = sync_pat ? (cyc % 37 == 5) : 1'b0;
      step(tag);
    end
    ring_msb_i = 1'b0;
    sync_rise_i = 1'b0;
  endtask

  task automatic set_step(input logic [15:0] f);
    wr(3'd0, f[7:0], "R11");
    wr(3'd1, f[15:8], "R11");
  endtask

  task automatic set_thr(input logic [11:0] p);
    wr(3'd2, p[7:0], "R11");
    wr(3'd3, {4'hA, p[11:8]}, "R11");
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R3: reset state visible at the ports
    chk("R3", int'(wave_o), 0);
    chk("R3", int'(msb_o), 0);
    chk("R3", int'(msb_rise_o), 0);
    rst_n = 1'b1;
    // R3: sawtooth with zero step shows the power-up phase 0x555
    wr(3'd4, 8'h20, "R4");
    step("R3");
    chk("R3", int'(wave_o), 12'h555);

    // R4 sawtooth with a fast and a slow step, including the wrap
    set_step(16'hFFFF);
    run(600, "R4");
    set_step(16'h1357);
    run(400, "R4");

    // R5 triangle
    wr(3'd4, 8'h10, "R5");
    set_step(16'hF0F1);
    run(600, "R5");

    // R6 triangle with ring modulation and a toggling neighbour MSB
    wr(3'd4, 8'h12, "R6");
    ring_pat = 1'b1;
    run(600, "R6");
    ring_pat = 1'b0;

    // R7 pulse threshold sweep
    wr(3'd4, 8'h40, "R7");
    set_step(16'hFFFF);
    for (int k = 0; k <= 16; k++) begin
      set_thr((k == 16) ? 12'hFFF : 12'(k * 256));
      run(280, "R7");
    end

    // R8 and R2: test forces pulse high and holds the phase at zero
    set_thr(12'hFFF);
    wr(3'd4, 8'h44, "R8");
    run(50, "R8");
    chk("R2", int'(msb_o), 0);
    wr(3'd4, 8'h60, "R2");
    run(300, "R2");

    // R10 hard sync from a periodic neighbour flag
    wr(3'd4, 8'h21, "R10");
    set_step(16'h2345);
    sync_pat = 1'b1;
    run(600, "R10");
    sync_pat = 1'b0;

    // R12 combined shapes; unused control bits are ignored
    set_thr(12'h6A5);
    wr(3'd4, 8'h38, "R12");
    run(300, "R12");
    wr(3'd4, 8'hD0, "R12");
    run(300, "R12");
    wr(3'd4, 8'h70, "R12");
    run(300, "R12");
    // R12 no shape selected: the last sample is held
    wr(3'd4, 8'h80, "R12");
    run(100, "R12");

    // R11 writes to unused addresses leave every register untouched
    wr(3'd5, 8'hFF, "R11");
    wr(3'd6, 8'hFF, "R11");
    wr(3'd7, 8'hFF, "R11");
    wr(3'd4, 8'h20, "R11");
    run(300, "R11");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule